// File: doc/BRIEF.md
# Dual-Mode Serial Control Port

This block is the slave side of a host control link. A host uses it to set up a device and to move bytes in and out of the device's register space. The `mode_sel` pin chooses the protocol. When it is low, the port is a two-wire I2C slave with an open-drain data line. When it is high, the port is a three-wire SPI slave with an active-low frame enable, serial input on the shared data pin and a separate serial output pin. Both modes use the same clock pin and the same data pin. When `mode_sel` and `spi_en_n` are both low, the whole port is held in reset. In I2C mode the enable pin can therefore act as a reset line.

All pins pass through two-flop synchronizers on the system clock, which must run at least eight times faster than SCK. START and STOP conditions and clock edges are found from the synchronized samples. On the inside the port drives a byte-wide register bus. `reg_we` and `reg_re` are single-cycle strobes. `reg_rdata` must show the contents at `reg_addr` in the cycle after `reg_re`.

Top module: `ser_ctl_port`

## Requirements
- R1: With `mode_sel` low the port follows the I2C protocol. With `mode_sel` high it follows SPI, and I2C address bytes get no acknowledge.
- R2: While the port is in I2C mode, `sdo_oe` stays low.
- R3: While `mode_sel` and `spi_en_n` are both low, the port releases SDA, issues no strobes and clears its register pointer to 0.
- R4: The I2C slave acknowledges only the address bytes 28h (write) and 29h (read), where bit 0 is the read flag. After any other address it leaves SDA released for the rest of that transfer.
- R5: In an I2C write, the first byte after the address sets the register pointer. Each later byte is written at the pointer, and the pointer then increments. Every byte is acknowledged by pulling SDA low in the ninth clock.
- R6: An I2C read starts at the current pointer. Bytes go out MSB first and the pointer increments after each one. A master NACK stops the transmission and the slave releases SDA.
- R7: START is SDA falling while SCK is high, and STOP is SDA rising while SCK is high. A repeated START begins a new address phase.
- R8: The I2C slave starts pulling SDA low only while SCK is low.
- R9: In SPI mode the first byte of a frame is a command: bit 7 set means read, and bits 6..0 are the register address. In a write frame, each following byte is written to successive addresses.
- R10: In an SPI read frame, the addressed register and the registers after it are shifted out on `sdo`, MSB first. The output changes only after SCK falling edges, so each bit is valid at the rising edge.
- R11: `sdo_oe` is high only in SPI mode while `spi_en_n` is low. Otherwise `sdo` is high-impedance.
- R12: `reg_we` and `reg_re` are single-cycle pulses that never occur together. A write strobe occurs only for a received data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCK |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Protocol select: 0 = I2C, 1 = SPI |
| spi_en_n | input | 1 | SPI frame enable, active low; must be high for I2C operation |
| sck | input | 1 | Serial clock from host |
| sda_in | input | 1 | Sensed level of the shared data pin |
| sda_oe | output | 1 | Pull the shared data pin low (open drain) |
| sdo | output | 1 | SPI serial output value |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high-impedance |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data for `reg_addr`, valid the cycle after `reg_re` |

## Verification
The in-RTL properties check several rules on every clock:
- `sdo` stays off in I2C mode and outside SPI frames.
- The port is quiet while the mode/enable reset pairing is held.
- The two strobes never overlap.
- SDA is only pulled low while the synchronized clock is low.
- The SPI shift register moves only after a falling edge or a read load.
- A NACKed slave keeps SDA released.

Address matching, pointer auto-increment across bytes and across transactions, repeated-START handling, MSB-first data content and pointer clearing under port reset depend on whole transfers. Only the bench's host-driven scenarios, with a register model, can show them.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    localparam int REG_AW = 7;
    localparam int BYTE_W = 8;

    // synchronizer bit positions
    localparam int PIN_SDA  = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_EN   = 2;
    localparam int PIN_MODE = 3;
    localparam int PIN_CNT  = 4;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [REG_AW-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } reg_req_t;

    typedef enum logic [2:0] {
        I2C_IDLE,
        I2C_ADDR,
        I2C_PTR,
        I2C_WDAT,
        I2C_RDAT,
        I2C_HOLD
    } i2c_state_e;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    function automatic logic [REG_AW-1:0] ptr_inc(input logic [REG_AW-1:0] p);
        return p + REG_AW'(1);
    endfunction

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= INIT[g];
                stab <= INIT[g];
            end else begin
                meta <= d[g];
                stab <= meta;
            end
        end
        assign q[g] = stab;
    end
endmodule

// File: rtl/ser_i2c_slv.sv
module ser_i2c_slv
    import ser_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output reg_req_t          req,
    output logic              sda_oe
);
    i2c_state_e        st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx, tx;
    logic [REG_AW-1:0] ptr;
    logic              ackd, rd, cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= I2C_IDLE; cnt <= '0; rx <= '0; tx <= '0; ptr <= '0;
            ackd <= 1'b0; rd <= 1'b0; cap <= 1'b0; sda_oe <= 1'b0; req <= '0;
        end else begin
            req.we <= 1'b0;
            req.re <= 1'b0;
            if (start_det) begin
                st <= I2C_ADDR; cnt <= '0; ackd <= 1'b0; cap <= 1'b0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= I2C_IDLE; ackd <= 1'b0; cap <= 1'b0; sda_oe <= 1'b0;
            end else if (cap) begin
                tx     <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                cap    <= 1'b0;
            end else begin
                case (st)
                    I2C_ADDR, I2C_PTR, I2C_WDAT: begin
                        if (scl_rise && cnt < 4'd8) begin
                            rx  <= {rx[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8 && !ackd) begin
                            ackd   <= 1'b1;
                            sda_oe <= 1'b1;
                            if (st == I2C_ADDR) begin
                                if (addr_hit(rx, DEV_ADDR)) rd <= rx[0];
                                else begin
                                    st <= I2C_HOLD; ackd <= 1'b0; sda_oe <= 1'b0;
                                end
                            end else if (st == I2C_PTR) begin
                                ptr <= rx[REG_AW-1:0];
                            end else begin
                                req.we    <= 1'b1;
                                req.addr  <= ptr;
                                req.wdata <= rx;
                                ptr       <= ptr_inc(ptr);
                            end
                        end else if (scl_fall && ackd) begin
                            ackd   <= 1'b0;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            if (st == I2C_ADDR && rd) begin
                                st       <= I2C_RDAT;
                                req.re   <= 1'b1;
                                req.addr <= ptr;
                                ptr      <= ptr_inc(ptr);
                                cap      <= 1'b1;
                            end else if (st == I2C_ADDR) begin
                                st <= I2C_PTR;
                            end else begin
                                st <= I2C_WDAT;
                            end
                        end
                    end
                    I2C_RDAT: begin
                        if (scl_rise) begin
                            if (cnt < 4'd8) cnt <= cnt + 4'd1;
                            else if (cnt == 4'd8) begin
                                if (sda_lvl) begin
                                    st <= I2C_HOLD; sda_oe <= 1'b0;
                                end else cnt <= 4'd9;
                            end
                        end else if (scl_fall) begin
                            if (cnt == 4'd9) begin
                                cnt      <= '0;
                                sda_oe   <= 1'b0;
                                req.re   <= 1'b1;
                                req.addr <= ptr;
                                ptr      <= ptr_inc(ptr);
                                cap      <= 1'b1;
                            end else if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                            end else if (cnt != 4'd0) begin
                                tx     <= {tx[BYTE_W-2:0], 1'b1};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl) else $error("SDA pulled while SCK high"); // R8
    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == I2C_HOLD) |-> !sda_oe) else $error("SDA driven after NACK/miss"); // R4

endmodule

// File: rtl/ser_spi_slv.sv
module ser_spi_slv
    import ser_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sdi_lvl,
    input  logic [BYTE_W-1:0] rdata,
    output reg_req_t          req,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [2:0]        cnt;
    logic [BYTE_W-2:0] rx;
    logic [BYTE_W-1:0] tx, byte_in;
    logic [REG_AW-1:0] addr;
    logic              first, rd, pend, cap;

    assign byte_in = {rx, sdi_lvl};
    assign sdo     = tx[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst || en_n_lvl) begin
            cnt <= '0; rx <= '0; tx <= '0; addr <= '0;
            first <= 1'b1; rd <= 1'b0; pend <= 1'b0; cap <= 1'b0;
            sdo_oe <= 1'b0; req <= '0;
        end else begin
            sdo_oe <= 1'b1;
            req.we <= 1'b0;
            req.re <= 1'b0;
            if (scl_rise) begin
                rx  <= byte_in[BYTE_W-2:0];
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                    first <= 1'b0;
                    if (first) begin
                        rd   <= byte_in[BYTE_W-1];
                        addr <= byte_in[REG_AW-1:0];
                        pend <= byte_in[BYTE_W-1];
                    end else if (rd) begin
                        pend <= 1'b1;
                    end else begin
                        req.we    <= 1'b1;
                        req.addr  <= addr;
                        req.wdata <= byte_in;
                        addr      <= ptr_inc(addr);
                    end
                end
            end else if (scl_fall) begin
                if (pend) begin
                    req.re   <= 1'b1;
                    req.addr <= addr;
                    addr     <= ptr_inc(addr);
                    pend     <= 1'b0;
                    cap      <= 1'b1;
                end else begin
                    tx <= {tx[BYTE_W-2:0], 1'b0};
                end
            end else if (cap) begin
                tx  <= rdata;
                cap <= 1'b0;
            end
        end
    end

    AST_TX_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tx) && sdo_oe && $past(sdo_oe)) |-> ($past(scl_fall) || $past(cap)))
        else $error("SDO changed off a falling edge"); // R10

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
    import ser_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              spi_en_n,
    input  logic              sck,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [PIN_CNT-1:0] pin_lvl;
    logic               sck_q, sda_q;
    logic               sck_rise, sck_fall, sda_rise, sda_fall;
    logic               port_hold, i2c_rst, spi_rst;
    reg_req_t           i2c_req, spi_req, bus_req;

    ser_sync #(.W(PIN_CNT), .INIT('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mode_sel, spi_en_n, sck, sda_in}),
        .q   (pin_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            sck_q <= pin_lvl[PIN_SCK];
            sda_q <= pin_lvl[PIN_SDA];
        end
    end

    assign sck_rise  =  pin_lvl[PIN_SCK] & ~sck_q;
    assign sck_fall  = ~pin_lvl[PIN_SCK] &  sck_q;
    assign sda_rise  =  pin_lvl[PIN_SDA] & ~sda_q;
    assign sda_fall  = ~pin_lvl[PIN_SDA] &  sda_q;

    assign port_hold = ~pin_lvl[PIN_MODE] & ~pin_lvl[PIN_EN];
    assign i2c_rst   = rst | port_hold | pin_lvl[PIN_MODE];
    assign spi_rst   = rst | ~pin_lvl[PIN_MODE];

    ser_i2c_slv #(.DEV_ADDR(DEV_ADDR)) u_i2c (
        .clk       (clk),
        .rst       (i2c_rst),
        .scl_lvl   (pin_lvl[PIN_SCK]),
        .scl_rise  (sck_rise),
        .scl_fall  (sck_fall),
        .sda_lvl   (pin_lvl[PIN_SDA]),
        .start_det (pin_lvl[PIN_SCK] & sda_fall),
        .stop_det  (pin_lvl[PIN_SCK] & sda_rise),
        .rdata     (reg_rdata),
        .req       (i2c_req),
        .sda_oe    (sda_oe)
    );

    ser_spi_slv u_spi (
        .clk      (clk),
        .rst      (spi_rst),
        .en_n_lvl (pin_lvl[PIN_EN]),
        .scl_rise (sck_rise),
        .scl_fall (sck_fall),
        .sdi_lvl  (pin_lvl[PIN_SDA]),
        .rdata    (reg_rdata),
        .req      (spi_req),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    assign bus_req   = pin_lvl[PIN_MODE] ? spi_req : i2c_req;
    assign reg_addr  = bus_req.addr;
    assign reg_wdata = bus_req.wdata;
    assign reg_we    = bus_req.we;
    assign reg_re    = bus_req.re;

    AST_SDO_OFF_I2C: assert property (@(posedge clk) disable iff (rst)
        !pin_lvl[PIN_MODE] |=> !sdo_oe) else $error("sdo enabled in I2C mode"); // R2
    AST_SDO_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        pin_lvl[PIN_EN] |=> !sdo_oe) else $error("sdo enabled outside frame"); // R11
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        port_hold |=> (!sda_oe && !reg_we && !reg_re)) else $error("activity in port reset"); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re)) else $error("both strobes"); // R12
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R12

endmodule

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;
    localparam int Q = 4;

    logic       clk = 1'b0, rst = 1'b1;
    logic       mode_sel = 1'b0, spi_en_n = 1'b1, sck = 1'b1, m_sda = 1'b1;
    logic       sda_oe, sdo, sdo_oe, reg_we, reg_re, sda_line;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    int checks = 0, errors = 0, r8_bad = 0, r12_bad = 0;

    typedef struct { logic [6:0] a; logic [7:0] d; string tag; } wr_t;
    wr_t wq[$];

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    ser_ctl_port dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .spi_en_n(spi_en_n),
        .sck(sck), .sda_in(sda_line), .sda_oe(sda_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: register file and scoreboard of write strobes
    initial begin
        logic prev_oe;
        prev_oe = 1'b0;
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (reg_we) begin
                    if (wq.size() == 0) chk(1'b0, "R12 unexpected write", {1'b0, reg_addr, reg_wdata}, 16'h0);
                    else begin
                        wr_t e;
                        e = wq.pop_front();
                        chk(e.a == reg_addr && e.d == reg_wdata, e.tag,
                            {1'b0, reg_addr, reg_wdata}, {1'b0, e.a, e.d});
                    end
                    mem[reg_addr] = reg_wdata;
                end
                if (reg_we && reg_re) r12_bad++;
                if (sda_oe && !prev_oe && sck) r8_bad++;
            end
            prev_oe = sda_oe;
        end
    end

    task automatic push_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        wr_t e;
        e.a = a; e.d = d; e.tag = tag;
        wq.push_back(e);
        exp_mem[a] = d;
    endtask

    task automatic i_start();
        m_sda = 1'b1; wt(Q); sck = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); sck = 1'b0; wt(Q);
    endtask

    task automatic i_stop();
        m_sda = 1'b0; wt(Q); sck = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic i_wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(Q); sck = 1'b1; wt(2 * Q); sck = 1'b0; wt(Q);
        end
        m_sda = 1'b1; wt(Q); sck = 1'b1; wt(Q); ack = !sda_line; wt(Q); sck = 1'b0; wt(Q);
    endtask

    task automatic i_rbyte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(2 * Q); sck = 1'b1; wt(Q); b[i] = sda_line; wt(Q); sck = 1'b0;
        end
        m_sda = nack; wt(2 * Q); sck = 1'b1; wt(2 * Q); sck = 1'b0; wt(Q); m_sda = 1'b1;
    endtask

    task automatic s_xfer(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            m_sda = t[i]; wt(Q); r[i] = sdo; sck = 1'b1; wt(2 * Q); sck = 1'b0; wt(Q);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 7 + 3);
        wt(5); rst = 1'b0; wt(6);
        chk(sda_oe == 1'b0, "R3 reset SDA released", 16'(sda_oe), 16'h0);
        chk(sdo_oe == 1'b0, "R2 reset sdo off", 16'(sdo_oe), 16'h0);

        // R5: I2C write with pointer and auto-increment
        i_start();
        i_wbyte(8'h28, ack); chk(ack, "R4 write address acked", 16'(ack), 16'h1);
        i_wbyte(8'h10, ack); chk(ack, "R5 pointer byte acked", 16'(ack), 16'h1);
        push_wr(7'h10, 8'hA5, "R5 write data 0"); i_wbyte(8'hA5, ack); chk(ack, "R5 data acked", 16'(ack), 16'h1);
        push_wr(7'h11, 8'h3C, "R5 write data 1"); i_wbyte(8'h3C, ack); chk(ack, "R5 data acked", 16'(ack), 16'h1);
        push_wr(7'h12, 8'h7E, "R5 write data 2"); i_wbyte(8'h7E, ack); chk(ack, "R5 data acked", 16'(ack), 16'h1);
        i_stop(); wt(4);
        chk(wq.size() == 0, "R5 all writes seen", 16'(wq.size()), 16'h0);

        // R7 repeated START into a read; R6 read with NACK
        i_start();
        i_wbyte(8'h28, ack); i_wbyte(8'h10, ack);
        i_start();
        i_wbyte(8'h29, ack); chk(ack, "R7 read address acked after repeated START", 16'(ack), 16'h1);
        i_rbyte(1'b0, b); chk(b == exp_mem[8'h10], "R6 read byte 0", 16'(b), 16'(exp_mem[8'h10]));
        chk(sdo_oe == 1'b0, "R2 sdo off during I2C transfer", 16'(sdo_oe), 16'h0);
        i_rbyte(1'b0, b); chk(b == exp_mem[8'h11], "R6 read byte 1", 16'(b), 16'(exp_mem[8'h11]));
        i_rbyte(1'b1, b); chk(b == exp_mem[8'h12], "R6 read byte 2", 16'(b), 16'(exp_mem[8'h12]));
        wt(2); chk(sda_oe == 1'b0, "R6 SDA released after NACK", 16'(sda_oe), 16'h0);
        i_stop();
        i_start();
        i_wbyte(8'h29, ack);
        i_rbyte(1'b1, b); chk(b == exp_mem[8'h13], "R6 read resumes at pointer", 16'(b), 16'(exp_mem[8'h13]));
        i_stop();

        // R4 foreign address
        i_start();
        i_wbyte(8'h50, ack); chk(!ack, "R4 foreign address not acked", 16'(ack), 16'h0);
        i_wbyte(8'h12, ack); chk(!ack, "R4 later byte not acked", 16'(ack), 16'h0);
        i_stop(); wt(4);

        // R3 port reset by enable low in I2C mode
        spi_en_n = 1'b0; wt(10);
        chk(sda_oe == 1'b0 && !reg_we, "R3 quiet in port reset", 16'(sda_oe), 16'h0);
        spi_en_n = 1'b1; wt(8);
        i_start();
        i_wbyte(8'h29, ack);
        i_rbyte(1'b1, b); chk(b == exp_mem[0], "R3 pointer cleared", 16'(b), 16'(exp_mem[0]));
        i_stop();

        // R1 SPI mode: I2C addressing has no effect
        mode_sel = 1'b1; wt(8);
        i_start();
        i_wbyte(8'h28, ack); chk(!ack, "R1 no I2C ack in SPI mode", 16'(ack), 16'h0);
        i_stop();
        sck = 1'b0; wt(8);
        chk(sdo_oe == 1'b0, "R11 sdo off while enable high", 16'(sdo_oe), 16'h0);

        // R9 SPI write frame
        push_wr(7'h20, 8'h11, "R9 SPI write 0");
        push_wr(7'h21, 8'h22, "R9 SPI write 1");
        spi_en_n = 1'b0; wt(Q);
        chk(sdo_oe == 1'b1, "R11 sdo driven in frame", 16'(sdo_oe), 16'h1);
        s_xfer(8'h20, b); s_xfer(8'h11, b); s_xfer(8'h22, b);
        wt(Q); spi_en_n = 1'b1; wt(8);
        chk(sdo_oe == 1'b0, "R11 sdo released after frame", 16'(sdo_oe), 16'h0);
        chk(wq.size() == 0, "R9 all SPI writes seen", 16'(wq.size()), 16'h0);

        // R10 SPI read frame
        spi_en_n = 1'b0; wt(Q);
        s_xfer(8'hA0, b);
        s_xfer(8'h00, b); chk(b == exp_mem[8'h20], "R10 SPI read 0", 16'(b), 16'(exp_mem[8'h20]));
        s_xfer(8'h00, b); chk(b == exp_mem[8'h21], "R10 SPI read 1", 16'(b), 16'(exp_mem[8'h21]));
        s_xfer(8'h00, b); chk(b == exp_mem[8'h22], "R10 SPI read 2", 16'(b), 16'(exp_mem[8'h22]));
        wt(Q); spi_en_n = 1'b1; wt(8);

        // back to I2C
        sck = 1'b1; m_sda = 1'b1; wt(4);
        mode_sel = 1'b0; wt(8);
        chk(sdo_oe == 1'b0, "R2 sdo off after return to I2C", 16'(sdo_oe), 16'h0);
        chk(r8_bad == 0, "R8 SDA pulled only while SCK low", 16'(r8_bad), 16'h0);
        chk(r12_bad == 0, "R12 strobes never together", 16'(r12_bad), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule